// File: doc/BRIEF.md
# Guest Entry Precondition Sequencer

This block screens a request to start or continue a guest. When a request pulse arrives it evaluates a short list of preconditions in a fixed priority. It then reports exactly one of four outcomes, one clock cycle later:

- a protection fault;
- a "no control structure" failure, signalled through the carry flag;
- a "bad structure state" failure, signalled through the zero flag together with a stored error number;
- a proceed indication that hands the request on to the later control-field and host-state validation.

The request carries a launch/resume selector. The remaining inputs describe the current privilege level, whether a control structure is loaded, whether interrupts are blocked by a recent stack-segment load, and whether the structure is in the launched state. The flag outputs are one-cycle update strobes that the surrounding flags logic applies. The error number output is a register. It changes only when a zero-flag failure is reported.

Top module: `gep_sequencer`

## Requirements
- R1: Synchronous active-high reset drives `fault_gp`, `set_cf`, `set_zf` and `proceed` to 0 and clears `err_num` to 0.
- R2: A request with `priv_level` not zero produces `fault_gp`=1 with `set_cf`, `set_zf` and `proceed` all 0, whatever the other inputs are, and leaves `err_num` unchanged.
- R3: A request at privilege 0 with `struct_present`=0 produces `set_cf`=1 with all other outcomes 0, and leaves `err_num` unchanged.
- R4: A request at privilege 0 with a structure present and `ss_blocked`=1 produces `set_zf`=1 and loads `err_num` with `ERR_SS_BLOCK` (default 1). This check takes priority over both launch-state checks.
- R5: With privilege 0, a structure present and no blocking, a launch request (`req_resume`=0) on a structure with `launched`=1 produces `set_zf`=1 and loads `err_num` with `ERR_LAUNCH` (default 2).
- R6: With privilege 0, a structure present and no blocking, a resume request (`req_resume`=1) on a structure with `launched`=0 produces `set_zf`=1 and loads `err_num` with `ERR_RESUME` (default 3).
- R7: When every precondition holds (launch on a clear structure, or resume on a launched one), `proceed`=1 with `set_cf`=0, `set_zf`=0 and `fault_gp`=0.
- R8: Outcomes are registered. They appear in the cycle after the clock edge that samples `req_valid`=1 and last one cycle. A cycle without a request yields no outcome. Requests on consecutive cycles are each answered.
- R9: At most one of `fault_gp`, `set_cf`, `set_zf`, `proceed` is 1 in any cycle, so the carry and zero strobes are never set together.
- R10: `err_num` keeps its value in every cycle in which `set_zf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Entry request pulse |
| req_resume | input | 1 | 0 = launch request, 1 = resume request |
| priv_level | input | PRIV_W | Current privilege level, 0 is most privileged |
| struct_present | input | 1 | A current control structure is loaded |
| ss_blocked | input | 1 | Blocking after a stack-segment load is active |
| launched | input | 1 | Structure launch state: 0 = clear, 1 = launched |
| fault_gp | output | 1 | General-protection fault strobe |
| set_cf | output | 1 | Set carry flag strobe (no structure) |
| set_zf | output | 1 | Set zero flag strobe (structure failure) |
| proceed | output | 1 | All preconditions met |
| err_num | output | ERR_W | Instruction-error number register |

## Verification
A wrong priority inside the classifier shows up one cycle after the offending request. It appears as the wrong strobe, or as the right strobe with the wrong error number; for example, a blocked request that reports a launch-state error. A stale or spuriously updated error register is only visible when a later non-zero-flag outcome arrives, so the vector table interleaves faults, carry failures and proceeds between zero-flag failures. Back-to-back requests expose a pulse that is held for more than one cycle or lost on the following request.

// File: rtl/gep_pkg.sv
package gep_pkg;

   typedef enum logic [1:0] {
      OUT_FAULT    = 2'd0,
      OUT_NOSTRUCT = 2'd1,
      OUT_BADSTATE = 2'd2,
      OUT_PROCEED  = 2'd3
   } outcome_e;

endpackage

// File: rtl/gep_classify.sv
module gep_classify #(
   parameter int PRIV_W       = 2,
   parameter int ERR_W        = 8,
   parameter int ERR_SS_BLOCK = 1,
   parameter int ERR_LAUNCH   = 2,
   parameter int ERR_RESUME   = 3
) (
   input  logic                req_resume,
   input  logic [PRIV_W-1:0]   priv_level,
   input  logic                struct_present,
   input  logic                ss_blocked,
   input  logic                launched,
   output gep_pkg::outcome_e   outcome,
   output logic [ERR_W-1:0]    err_code
);
   import gep_pkg::*;

   localparam logic [ERR_W-1:0] CODE_SS = ERR_W'(ERR_SS_BLOCK);
   localparam logic [ERR_W-1:0] CODE_LA = ERR_W'(ERR_LAUNCH);
   localparam logic [ERR_W-1:0] CODE_RE = ERR_W'(ERR_RESUME);

   logic launch_bad;
   logic resume_bad;

   assign launch_bad = !req_resume && launched;
   assign resume_bad = req_resume && !launched;

   // Fixed priority: privilege, presence, blocking, launch state, resume state
   always_comb begin
      outcome  = OUT_PROCEED;
      err_code = '0;
      if (priv_level != '0) begin
         outcome = OUT_FAULT;
      end else if (!struct_present) begin
         outcome = OUT_NOSTRUCT;
      end else if (ss_blocked) begin
         outcome  = OUT_BADSTATE;
         err_code = CODE_SS;
      end else if (launch_bad) begin
         outcome  = OUT_BADSTATE;
         err_code = CODE_LA;
      end else if (resume_bad) begin
         outcome  = OUT_BADSTATE;
         err_code = CODE_RE;
      end
   end

endmodule

// File: rtl/gep_outreg.sv
module gep_outreg #(
   parameter int ERR_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  gep_pkg::outcome_e  outcome,
   input  logic [ERR_W-1:0]   err_code,
   output logic               fault_gp,
   output logic               set_cf,
   output logic               set_zf,
   output logic               proceed,
   output logic [ERR_W-1:0]   err_num
);
   import gep_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         fault_gp <= 1'b0;
         set_cf   <= 1'b0;
         set_zf   <= 1'b0;
         proceed  <= 1'b0;
         err_num  <= '0;
      end else begin
         fault_gp <= req_valid && (outcome == OUT_FAULT);
         set_cf   <= req_valid && (outcome == OUT_NOSTRUCT);
         set_zf   <= req_valid && (outcome == OUT_BADSTATE);
         proceed  <= req_valid && (outcome == OUT_PROCEED);
         if (req_valid && (outcome == OUT_BADSTATE)) begin
            err_num <= err_code;
         end
      end
   end

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !set_zf |-> $stable(err_num)); // R10

endmodule

// File: rtl/gep_sequencer.sv
module gep_sequencer #(
   parameter int PRIV_W       = 2,
   parameter int ERR_W        = 8,
   parameter int ERR_SS_BLOCK = 1,
   parameter int ERR_LAUNCH   = 2,
   parameter int ERR_RESUME   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  logic               req_resume,
   input  logic [PRIV_W-1:0]  priv_level,
   input  logic               struct_present,
   input  logic               ss_blocked,
   input  logic               launched,
   output logic               fault_gp,
   output logic               set_cf,
   output logic               set_zf,
   output logic               proceed,
   output logic [ERR_W-1:0]   err_num
);
   import gep_pkg::*;

   localparam longint ERR_MAX = (64'd1 << ERR_W) - 1;

   generate
      if (PRIV_W < 1) begin : g_bad_priv
         $error("PRIV_W must be at least 1");
      end
      if (ERR_W < 2 || ERR_W > 32) begin : g_bad_errw
         $error("ERR_W must lie in 2..32");
      end
      if (ERR_SS_BLOCK == ERR_LAUNCH || ERR_SS_BLOCK == ERR_RESUME ||
          ERR_LAUNCH == ERR_RESUME) begin : g_dup_err
         $error("error numbers must be distinct");
      end
      if (ERR_SS_BLOCK <= 0 || ERR_LAUNCH <= 0 || ERR_RESUME <= 0 ||
          longint'(ERR_SS_BLOCK) > ERR_MAX || longint'(ERR_LAUNCH) > ERR_MAX ||
          longint'(ERR_RESUME) > ERR_MAX) begin : g_range_err
         $error("error numbers must be nonzero and fit ERR_W");
      end
   endgenerate

   outcome_e          cls_outcome;
   logic [ERR_W-1:0]  cls_err;

   gep_classify #(
      .PRIV_W       (PRIV_W),
      .ERR_W        (ERR_W),
      .ERR_SS_BLOCK (ERR_SS_BLOCK),
      .ERR_LAUNCH   (ERR_LAUNCH),
      .ERR_RESUME   (ERR_RESUME)
   ) u_classify (
      .req_resume     (req_resume),
      .priv_level     (priv_level),
      .struct_present (struct_present),
      .ss_blocked     (ss_blocked),
      .launched       (launched),
      .outcome        (cls_outcome),
      .err_code       (cls_err)
   );

   gep_outreg #(
      .ERR_W (ERR_W)
   ) u_outreg (
      .clk      (clk),
      .rst      (rst),
      .req_valid(req_valid),
      .outcome  (cls_outcome),
      .err_code (cls_err),
      .fault_gp (fault_gp),
      .set_cf   (set_cf),
      .set_zf   (set_zf),
      .proceed  (proceed),
      .err_num  (err_num)
   );

   logic base_ok;
   assign base_ok = (priv_level == '0) && struct_present && !ss_blocked;

   AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (rst)
      req_valid && (priv_level != '0) |=> fault_gp && !set_cf && !set_zf && !proceed
                                          && $stable(err_num)); // R2
   AST_NO_STRUCT: assert property (@(posedge clk) disable iff (rst)
      req_valid && (priv_level == '0) && !struct_present |=> set_cf && !set_zf
                                                            && $stable(err_num)); // R3
   AST_SS_BLOCK: assert property (@(posedge clk) disable iff (rst)
      req_valid && (priv_level == '0) && struct_present && ss_blocked
      |=> set_zf && (err_num == ERR_W'(ERR_SS_BLOCK))); // R4
   AST_LAUNCH_STATE: assert property (@(posedge clk) disable iff (rst)
      req_valid && base_ok && !req_resume && launched
      |=> set_zf && (err_num == ERR_W'(ERR_LAUNCH))); // R5
   AST_RESUME_STATE: assert property (@(posedge clk) disable iff (rst)
      req_valid && base_ok && req_resume && !launched
      |=> set_zf && (err_num == ERR_W'(ERR_RESUME))); // R6
   AST_PROCEED: assert property (@(posedge clk) disable iff (rst)
      req_valid && base_ok && (req_resume == launched)
      |=> proceed && !set_cf && !set_zf && !fault_gp); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !fault_gp && !set_cf && !set_zf && !proceed); // R8
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
      $onehot0({fault_gp, set_cf, set_zf, proceed})); // R9

endmodule

// File: tb/gep_sequencer_test.sv
module gep_sequencer_test;

   localparam int ERR_W = 8;

   logic             clk = 1'b0;
   logic             rst;
   logic             req_valid;
   logic             req_resume;
   logic [1:0]       priv_level;
   logic             struct_present;
   logic             ss_blocked;
   logic             launched;
   logic             fault_gp;
   logic             set_cf;
   logic             set_zf;
   logic             proceed;
   logic [ERR_W-1:0] err_num;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   gep_sequencer uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_resume(req_resume),
      .priv_level(priv_level), .struct_present(struct_present),
      .ss_blocked(ss_blocked), .launched(launched), .fault_gp(fault_gp),
      .set_cf(set_cf), .set_zf(set_zf), .proceed(proceed), .err_num(err_num)
   );

   // outcome codes: 0 none, 1 fault, 2 carry, 3 zero, 4 proceed
   // vector: resume, priv[1:0], present, ss, launched, outcome[2:0], err[7:0]
   localparam int NV = 12;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 3'd1, 8'd0},
      {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2, 8'd0},
      {1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 3'd3, 8'd1},
      {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 3'd3, 8'd2},
      {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd4, 8'd2},
      {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 8'd3},
      {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 3'd1, 8'd3},
      {1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 3'd4, 8'd3},
      {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd2, 8'd3},
      {1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 3'd3, 8'd1},
      {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 3'd1, 8'd1},
      {1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 3'd3, 8'd1}
   };

   function automatic logic [3:0] strobes_for(input logic [2:0] oc);
      case (oc)
         3'd1:    return 4'b1000;
         3'd2:    return 4'b0100;
         3'd3:    return 4'b0010;
         3'd4:    return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic string tag_for(input logic [2:0] oc, input logic [7:0] e);
      case (oc)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return (e == 8'd1) ? "R4" : (e == 8'd2) ? "R5" : "R6";
         3'd4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] strobes();
      return {fault_gp, set_cf, set_zf, proceed};
   endfunction

   task automatic drive_idle();
      req_valid = 1'b0; req_resume = 1'b0; priv_level = 2'd0;
      struct_present = 1'b0; ss_blocked = 1'b0; launched = 1'b0;
   endtask

   initial begin
      rst = 1'b1;
      drive_idle();
      repeat (3) @(posedge clk);
      #2;
      check("R1 strobes after reset", 16'(strobes()), 16'h0);
      check("R1 err after reset", 16'(err_num), 16'h0);
      @(negedge clk);
      rst = 1'b0;

      // table walk: one request every cycle (back-to-back, R8)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req_valid      = 1'b1;
         req_resume     = VEC[i][16];
         priv_level     = VEC[i][15:14];
         struct_present = VEC[i][13];
         ss_blocked     = VEC[i][12];
         launched       = VEC[i][11];
         @(posedge clk);
         #2;
         check({tag_for(VEC[i][10:8], VEC[i][7:0]), " outcome"},
               16'(strobes()), 16'(strobes_for(VEC[i][10:8])));
         check((VEC[i][10:8] == 3'd3) ? "R4/5/6 err" : "R10 err held",
               16'(err_num), 16'(VEC[i][7:0]));
         check("R9 single outcome", 16'($countones(strobes()) <= 1), 16'h1);
      end

      // no request: no outcome, error held (R8, R10)
      @(negedge clk);
      drive_idle();
      ss_blocked = 1'b1; struct_present = 1'b1;
      @(posedge clk);
      #2;
      check("R8 idle quiet", 16'(strobes()), 16'h0);
      check("R10 idle err held", 16'(err_num), 16'd1);

      // single pulse then idle: outcome lasts exactly one cycle (R8)
      @(negedge clk);
      req_valid = 1'b1; req_resume = 1'b1; priv_level = 2'd0;
      struct_present = 1'b1; ss_blocked = 1'b0; launched = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check("R6 err after pulse", 16'(err_num), 16'd3);
      check("R8 pulse present", 16'(strobes()), 16'b0010);
      @(posedge clk);
      #2;
      check("R8 pulse one cycle", 16'(strobes()), 16'h0);

      // reset clears error register (R1)
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      check("R1 err cleared by reset", 16'(err_num), 16'h0);
      check("R1 strobes cleared by reset", 16'(strobes()), 16'h0);
      @(negedge clk);
      rst = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule